// File: doc/BRIEF.md
# L1 Pending-Miss Same-Line Coalescer

A direct-mapped level-one data cache controller that sits between a compute unit and the level-two cache. It accepts three kinds of requests: cacheable loads, write-through stores and bypassing loads. It tracks each set with a tag and a three-way line state: invalid, fill outstanding, or valid. The data path is outside this block. A cacheable load that misses sends one fill request down and marks its set as waiting for that fill. Any later request that names the same line is parked in a small local queue and does not travel to the level-two cache.

When the fill comes back, the line becomes valid, the waiting entries are woken, and they replay one per cycle in the order they arrived. Replayed loads then complete as local hits. A cacheable load to the same set with another tag may take the set over while a fill is outstanding. The stale fill still completes its own load and wakes its own waiters, but it leaves the set alone. Bypassing loads and stores never allocate. They only wait when they meet an outstanding fill to their own line.

Two counters, one for load hits and one for load misses, stop at their maximum value.

Top module: `l1pc_coalescer`

## Requirements
- R1: A cacheable load (`req_kind` 0) whose line is not valid counts one miss. It issues exactly one level-two request one cycle after acceptance, with `l2_req_kind` 0, the line-aligned address (offset bits zero) and the requester's id. The set then holds that tag in the waiting state.
- R2: Any request to a line whose fill is outstanding is parked. This applies to loads, stores (kind 1) and bypassing loads (kind 2). A parked request issues no level-two request and gives no hit while parked.
- R3: A level-two response with `l2_rsp_bypass` 0 is a fill. One cycle later it appears on `ret_valid`/`ret_id` and turns a waiting line with a matching tag into a valid line. Parked entries then replay one per cycle in arrival order, starting the cycle after the fill, and replayed loads report on `hit_valid`/`hit_id`. A load accepted in the same cycle as its line's fill is a hit.
- R4: Three back-to-back loads to different words of one invalid line count as one miss and two hits.
- R5: A cacheable load to the same set with a different tag, arriving while a fill is outstanding, misses at once and takes the set. The older fill still returns its id and wakes its own waiters, but the set stays waiting on the newer tag.
- R6: A bypassing load or store that arrives after an outstanding fill waits behind it. A bypassing load issued before the fill request goes out with `l2_req_kind` 2. Its response (`l2_rsp_bypass` 1) returns its id on `ret_valid` and leaves the set state unchanged.
- R7: A store goes out with `l2_req_kind` 1 and its full address one cycle after acceptance. It never allocates, so a later load to that line misses. Back-to-back stores to one line are both accepted with no stall.
- R8: The park queue holds QDEPTH entries (4 by default). `req_ready` is low while the queue is full and in every cycle in which a woken entry replays.
- R9: The hit and miss counters are CNT_W bits wide (32 by default) and hold at all-ones instead of wrapping.
- R10: After reset, all lines are invalid, the counters read zero, no output valid is high and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted at the next edge when valid |
| req_kind | input | 2 | 0 cacheable load, 1 store, 2 bypassing load |
| req_addr | input | ADDR_W | Word address |
| req_id | input | ID_W | Requester tag |
| l2_req_valid | output | 1 | Request to the level-two cache |
| l2_req_kind | output | 2 | 0 fill, 1 store, 2 bypassing load |
| l2_req_addr | output | ADDR_W | Line-aligned for fills, full address otherwise |
| l2_req_id | output | ID_W | Tag of the originating request |
| l2_rsp_valid | input | 1 | Response from the level-two cache |
| l2_rsp_bypass | input | 1 | 1 when the response answers a bypassing load |
| l2_rsp_addr | input | ADDR_W | Address of the answered request |
| l2_rsp_id | input | ID_W | Tag of the answered request |
| hit_valid | output | 1 | A load completed locally as a hit |
| hit_id | output | ID_W | Tag of that load |
| ret_valid | output | 1 | A level-two response completed its request |
| ret_id | output | ID_W | Tag of that request |
| hit_count | output | CNT_W | Saturating load-hit count |
| miss_count | output | CNT_W | Saturating load-miss count |

## Verification
A fill and a lookup of the same line can fall in the same cycle. The fill must then count for the lookup, which becomes a hit rather than a park, or the request would wait for a wakeup that has already gone by. The bench provokes this by driving a fill and a same-line load in one cycle, and expects a hit for the load together with the fill's return. A replay of a woken entry and a fresh request can also meet. The bench fills the queue, returns the fill, and checks that `req_ready` stays low while exactly one hit comes out per cycle.

// File: rtl/l1pc_pkg.sv
`timescale 1ns/1ps
package l1pc_pkg;
  typedef enum logic [1:0] {
    K_LOAD   = 2'd0,
    K_STORE  = 2'd1,
    K_BYPASS = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    LS_INV  = 2'd0,
    LS_PEND = 2'd1,
    LS_VAL  = 2'd2
  } line_st_e;
endpackage

// File: rtl/l1pc_line_table.sv
`timescale 1ns/1ps
module l1pc_line_table import l1pc_pkg::*; #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output line_st_e         rd_st,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             byp_rsp
);
  localparam int SETS = 1 << IDX_W;

  line_st_e         st_q  [SETS];
  logic [TAG_W-1:0] tag_q [SETS];

  assign rd_st  = st_q[rd_idx];
  assign rd_tag = tag_q[rd_idx];

  always_ff @(posedge clk) begin
    for (int i = 0; i < SETS; i++) begin
      if (!rst_n) begin
        st_q[i]  <= LS_INV;
        tag_q[i] <= '0;
      end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
        st_q[i]  <= LS_PEND;
        tag_q[i] <= alloc_tag;
      end else if (fill_en && fill_idx == IDX_W'(i) &&
                   st_q[i] == LS_PEND && tag_q[i] == fill_tag) begin
        st_q[i]  <= LS_VAL;
      end
    end
  end

  for (genvar g = 0; g < SETS; g++) begin : g_set_chk
    assert_bypass_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_rsp && !(alloc_en && alloc_idx == IDX_W'(g))) |=> (st_q[g] == $past(st_q[g])));
  end
endmodule

// File: rtl/l1pc_park_queue.sv
`timescale 1ns/1ps
module l1pc_park_queue #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int ID_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [1:0]              push_kind,
  input  logic [ADDR_W-1:0]       push_addr,
  input  logic [ID_W-1:0]         push_id,
  input  logic                    push_woken,
  input  logic                    pop,
  input  logic                    wake_en,
  input  logic [ADDR_W-OFF_W-1:0] wake_line,
  input  logic [ADDR_W-OFF_W-1:0] probe_line,
  output logic                    probe_hit,
  output logic                    head_ready,
  output logic [1:0]              head_kind,
  output logic [ADDR_W-1:0]       head_addr,
  output logic [ID_W-1:0]         head_id,
  output logic                    full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]        q_kind  [DEPTH];
  logic [ADDR_W-1:0] q_addr  [DEPTH];
  logic [ID_W-1:0]   q_id    [DEPTH];
  logic [DEPTH-1:0]  q_vld, q_woken;
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (count == CNT_W'(DEPTH));
  assign head_ready = q_vld[head] && q_woken[head];
  assign head_kind  = q_kind[head];
  assign head_addr  = q_addr[head];
  assign head_id    = q_id[head];

  always_comb begin
    probe_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (q_vld[i] && q_addr[i][ADDR_W-1:OFF_W] == probe_line) probe_hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      count <= '0;
      q_vld <= '0;
      q_woken <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_kind[i] <= '0;
        q_addr[i] <= '0;
        q_id[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && tail == PTR_W'(i)) begin
          q_kind[i]  <= push_kind;
          q_addr[i]  <= push_addr;
          q_id[i]    <= push_id;
          q_vld[i]   <= 1'b1;
          q_woken[i] <= push_woken;
        end else if (pop && head == PTR_W'(i)) begin
          q_vld[i] <= 1'b0;
        end else if (wake_en && q_vld[i] && q_addr[i][ADDR_W-1:OFF_W] == wake_line) begin
          q_woken[i] <= 1'b1;
        end
      end
      if (push) tail <= ptr_next(tail);
      if (pop)  head <= ptr_next(head);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count < CNT_W'(DEPTH)));
  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/l1pc_sat_counter.sv
`timescale 1ns/1ps
module l1pc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] MAXV = '1;

  function automatic logic [W-1:0] sat_next(input logic [W-1:0] v, input logic up);
    return (up && v != MAXV) ? v + 1'b1 : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= sat_next(value, inc);
  end

  assert_saturate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (value == MAXV) |=> (value == MAXV));
endmodule

// File: rtl/l1pc_coalescer.sv
`timescale 1ns/1ps
module l1pc_coalescer import l1pc_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 4,
  parameter int ID_W   = 4,
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  output logic              l2_req_valid,
  output logic [1:0]        l2_req_kind,
  output logic [ADDR_W-1:0] l2_req_addr,
  output logic [ID_W-1:0]   l2_req_id,
  input  logic              l2_rsp_valid,
  input  logic              l2_rsp_bypass,
  input  logic [ADDR_W-1:0] l2_rsp_addr,
  input  logic [ID_W-1:0]   l2_rsp_id,
  output logic              hit_valid,
  output logic [ID_W-1:0]   hit_id,
  output logic              ret_valid,
  output logic [ID_W-1:0]   ret_id,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction
  function automatic logic [IDX_W-1:0] idx_of(input logic [LINE_W-1:0] l);
    return l[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_W-1:0] l);
    return l[LINE_W-1:IDX_W];
  endfunction

  // queue side
  logic              head_ready, q_full, probe_hit;
  logic [1:0]        head_kind;
  logic [ADDR_W-1:0] head_addr;
  logic [ID_W-1:0]   head_id;

  // lookup slot: a woken entry replays ahead of new requests
  logic              ev_replay, req_fire, lk_valid;
  logic [1:0]        lk_kind;
  logic [ADDR_W-1:0] lk_addr;
  logic [ID_W-1:0]   lk_id;
  logic [LINE_W-1:0] lk_line, fill_line;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag, rd_tag;
  line_st_e          rd_st;

  // named events
  logic ev_fill, ev_fill_same, ev_pend, ev_valid, ev_park, ev_act;
  logic ev_hit, ev_miss, ev_issue;

  assign ev_replay = head_ready;
  assign req_ready = !head_ready && !q_full;
  assign req_fire  = req_valid && req_ready;
  assign lk_valid  = ev_replay || req_fire;

  always_comb begin
    if (ev_replay) begin
      lk_kind = head_kind;
      lk_addr = head_addr;
      lk_id   = head_id;
    end else begin
      lk_kind = req_kind;
      lk_addr = req_addr;
      lk_id   = req_id;
    end
  end

  assign lk_line   = line_of(lk_addr);
  assign lk_idx    = idx_of(lk_line);
  assign lk_tag    = tag_of(lk_line);
  assign fill_line = line_of(l2_rsp_addr);
  assign ev_fill   = l2_rsp_valid && !l2_rsp_bypass;

  // a fill arriving this cycle already counts for a same-line lookup
  assign ev_fill_same = ev_fill && (fill_line == lk_line);
  assign ev_pend  = (rd_st == LS_PEND) && (rd_tag == lk_tag) && !ev_fill_same;
  assign ev_valid = (rd_tag == lk_tag) &&
                    ((rd_st == LS_VAL) || (rd_st == LS_PEND && ev_fill_same));
  // new requests also queue behind earlier parked ones of their line
  assign ev_park  = lk_valid && (ev_pend || (probe_hit && !ev_replay));
  assign ev_act   = lk_valid && !ev_park;
  assign ev_hit   = ev_act && (lk_kind == K_LOAD) && ev_valid;
  assign ev_miss  = ev_act && (lk_kind == K_LOAD) && !ev_valid;
  assign ev_issue = ev_act && !ev_hit;

  l1pc_line_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (lk_idx),
    .rd_st     (rd_st),
    .rd_tag    (rd_tag),
    .alloc_en  (ev_miss),
    .alloc_idx (lk_idx),
    .alloc_tag (lk_tag),
    .fill_en   (ev_fill),
    .fill_idx  (idx_of(fill_line)),
    .fill_tag  (tag_of(fill_line)),
    .byp_rsp   (l2_rsp_valid && l2_rsp_bypass)
  );

  l1pc_park_queue #(.DEPTH(QDEPTH), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ID_W(ID_W)) i_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (ev_park),
    .push_kind  (lk_kind),
    .push_addr  (lk_addr),
    .push_id    (lk_id),
    .push_woken (!ev_pend),
    .pop        (ev_replay),
    .wake_en    (ev_fill),
    .wake_line  (fill_line),
    .probe_line (lk_line),
    .probe_hit  (probe_hit),
    .head_ready (head_ready),
    .head_kind  (head_kind),
    .head_addr  (head_addr),
    .head_id    (head_id),
    .full       (q_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l2_req_valid <= 1'b0;
      l2_req_kind  <= '0;
      l2_req_addr  <= '0;
      l2_req_id    <= '0;
      hit_valid    <= 1'b0;
      hit_id       <= '0;
      ret_valid    <= 1'b0;
      ret_id       <= '0;
    end else begin
      l2_req_valid <= ev_issue;
      l2_req_kind  <= lk_kind;
      l2_req_addr  <= (lk_kind == K_LOAD) ? {lk_line, {OFF_W{1'b0}}} : lk_addr;
      l2_req_id    <= lk_id;
      hit_valid    <= ev_hit;
      hit_id       <= lk_id;
      ret_valid    <= l2_rsp_valid;
      ret_id       <= l2_rsp_id;
    end
  end

  l1pc_sat_counter #(.W(CNT_W)) i_hits (
    .clk(clk), .rst_n(rst_n), .inc(ev_hit), .value(hit_count));
  l1pc_sat_counter #(.W(CNT_W)) i_misses (
    .clk(clk), .rst_n(rst_n), .inc(ev_miss), .value(miss_count));

  assert_miss_issues_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (l2_req_valid && l2_req_kind == K_LOAD && l2_req_id == $past(lk_id)));
  assert_park_is_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_park |=> (!l2_req_valid && !hit_valid));
  assert_replay_stalls_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    head_ready |-> !req_ready);
endmodule

// File: tb/test_l1pc_coalescer.sv
`timescale 1ns/1ps
module test_l1pc_coalescer;
  localparam int AW = 16, IW = 4, CW = 4;
  localparam logic [1:0] KL = 2'd0, KS = 2'd1, KB = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = '0;
  logic [AW-1:0] req_addr = '0;
  logic [IW-1:0] req_id = '0;
  logic l2_req_valid;
  logic [1:0] l2_req_kind;
  logic [AW-1:0] l2_req_addr;
  logic [IW-1:0] l2_req_id;
  logic l2_rsp_valid = 1'b0, l2_rsp_bypass = 1'b0;
  logic [AW-1:0] l2_rsp_addr = '0;
  logic [IW-1:0] l2_rsp_id = '0;
  logic hit_valid, ret_valid;
  logic [IW-1:0] hit_id, ret_id;
  logic [CW-1:0] hit_count, miss_count;

  int checks = 0, fails = 0, exp_h = 0, exp_m = 0;
  int   hit_q[$], ret_q[$], l2_q[$];
  string hit_t[$], ret_t[$], l2_t[$];

  always #5 clk = ~clk;

  l1pc_coalescer #(.CNT_W(CW)) i_l1pc_coalescer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_id(req_id),
    .l2_req_valid(l2_req_valid), .l2_req_kind(l2_req_kind),
    .l2_req_addr(l2_req_addr), .l2_req_id(l2_req_id),
    .l2_rsp_valid(l2_rsp_valid), .l2_rsp_bypass(l2_rsp_bypass),
    .l2_rsp_addr(l2_rsp_addr), .l2_rsp_id(l2_rsp_id),
    .hit_valid(hit_valid), .hit_id(hit_id), .ret_valid(ret_valid), .ret_id(ret_id),
    .hit_count(hit_count), .miss_count(miss_count));

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int t, input int i, input int w);
    return {t[9:0], i[3:0], w[1:0]};
  endfunction

  function automatic int sat(input int v);
    return (v > 15) ? 15 : v;
  endfunction

  function automatic int pack_l2(input logic [1:0] k, input logic [15:0] a, input logic [3:0] id);
    return int'({k, a, id});
  endfunction

  task automatic exp_hit(input int id, input string r);  hit_q.push_back(id); hit_t.push_back(r); endtask
  task automatic exp_ret(input int id, input string r);  ret_q.push_back(id); ret_t.push_back(r); endtask
  task automatic exp_l2(input logic [1:0] k, input logic [15:0] a, input logic [3:0] id, input string r);
    l2_q.push_back(pack_l2(k, a, id)); l2_t.push_back(r);
  endtask

  // scoreboard monitor: outputs are registered, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (hit_valid) begin
        if (hit_q.size() == 0) check(1'b0, "R2", "unexpected hit id", int'(hit_id), -1);
        else begin
          automatic int e = hit_q.pop_front();
          automatic string r = hit_t.pop_front();
          check(int'(hit_id) == e, r, "hit id", int'(hit_id), e);
        end
      end
      if (ret_valid) begin
        if (ret_q.size() == 0) check(1'b0, "R3", "unexpected return id", int'(ret_id), -1);
        else begin
          automatic int e = ret_q.pop_front();
          automatic string r = ret_t.pop_front();
          check(int'(ret_id) == e, r, "return id", int'(ret_id), e);
        end
      end
      if (l2_req_valid) begin
        automatic int a = pack_l2(l2_req_kind, l2_req_addr, l2_req_id);
        if (l2_q.size() == 0) check(1'b0, "R2", "unexpected L2 request", a, -1);
        else begin
          automatic int e = l2_q.pop_front();
          automatic string r = l2_t.pop_front();
          check(a == e, r, "L2 request {kind,addr,id}", a, e);
        end
      end
    end
  end

  // one cycle of stimulus, request and/or level-two response; called at a falling edge
  task automatic step(input bit rq, input logic [1:0] k, input logic [15:0] a, input int id,
                      input bit rs, input bit byp, input logic [15:0] ra, input int rid);
    if (rq) while (!req_ready) @(negedge clk);
    req_valid = rq; req_kind = k; req_addr = a; req_id = id[3:0];
    l2_rsp_valid = rs; l2_rsp_bypass = byp; l2_rsp_addr = ra; l2_rsp_id = rid[3:0];
    @(negedge clk);
    req_valid = 1'b0; l2_rsp_valid = 1'b0;
  endtask

  task automatic send(input logic [1:0] k, input logic [15:0] a, input int id);
    step(1'b1, k, a, id, 1'b0, 1'b0, '0, 0);
  endtask
  task automatic rsp(input bit byp, input logic [15:0] a, input int id);
    step(1'b0, KL, '0, 0, 1'b1, byp, a, id);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic counts(input string r);
    check(int'(hit_count) == sat(exp_h), r, "hit_count", int'(hit_count), sat(exp_h));
    check(int'(miss_count) == sat(exp_m), r, "miss_count", int'(miss_count), sat(exp_m));
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2000000;
    check(1'b0, "R3", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] la, lb, lc, ld, le, lf, lg, lh;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!hit_valid && !ret_valid && !l2_req_valid, "R10", "valids in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "req_ready after reset", int'(req_ready), 1);
    counts("R10");

    // R1 R2 R3 R4: three loads to one line -> one miss, two hits
    la = mk(1, 1, 0);
    exp_l2(KL, la, 1, "R1");
    send(KL, la, 1); send(KL, la + 1, 2); send(KL, la + 2, 3);
    exp_m++;
    idle(2);
    counts("R2");
    exp_ret(1, "R3"); exp_hit(2, "R4"); exp_hit(3, "R4");
    rsp(1'b0, la, 1);
    idle(4);
    exp_h += 2;
    counts("R4");

    // R3: hit on a valid line
    exp_hit(4, "R3");
    send(KL, la + 3, 4);
    idle(2);
    exp_h++;
    counts("R3");

    // R3: fill and same-line load in one cycle -> hit
    lb = mk(2, 2, 0);
    exp_l2(KL, lb, 5, "R1");
    send(KL, lb, 5);
    idle(1);
    exp_ret(5, "R3"); exp_hit(6, "R3");
    step(1'b1, KL, lb + 1, 6, 1'b1, 1'b0, lb, 5);
    idle(2);
    exp_m++; exp_h++;
    counts("R3");

    // R5: set conflict while pending
    lc = mk(3, 3, 0); ld = mk(4, 3, 0);
    exp_l2(KL, lc, 7, "R1");
    send(KL, lc, 7);
    send(KS, lc + 1, 8);
    exp_l2(KL, ld, 9, "R5");
    send(KL, ld, 9);
    exp_m += 2;
    idle(2);
    exp_ret(7, "R5"); exp_l2(KS, lc + 1, 8, "R5");
    rsp(1'b0, lc, 7);
    idle(3);
    send(KL, ld + 1, 10);
    idle(2);
    counts("R5");
    exp_ret(9, "R5"); exp_hit(10, "R5");
    rsp(1'b0, ld, 9);
    idle(3);
    exp_h++;
    counts("R5");

    // R6: bypass and store after the pending load wait behind it
    le = mk(5, 4, 0);
    exp_l2(KL, le, 11, "R1");
    send(KL, le, 11);
    send(KB, le + 2, 12);
    send(KS, le + 3, 13);
    exp_m++;
    idle(2);
    exp_ret(11, "R6"); exp_l2(KB, le + 2, 12, "R6"); exp_l2(KS, le + 3, 13, "R6");
    rsp(1'b0, le, 11);
    idle(3);
    exp_ret(12, "R6");
    rsp(1'b1, le + 2, 12);
    idle(2);

    // R6: earlier bypass returns first; line stays pending
    lf = mk(6, 5, 0);
    exp_l2(KB, lf, 14, "R6");
    send(KB, lf, 14);
    exp_l2(KL, lf, 15, "R1");
    send(KL, lf + 1, 15);
    exp_m++;
    exp_ret(14, "R6");
    rsp(1'b1, lf, 14);
    idle(1);
    send(KL, lf + 2, 1);
    idle(2);
    counts("R6");
    exp_ret(15, "R6"); exp_hit(1, "R6");
    rsp(1'b0, lf, 15);
    idle(3);
    exp_h++;
    counts("R6");

    // R7: stores back to back, no allocation
    lg = mk(7, 6, 0);
    exp_l2(KS, lg, 2, "R7"); exp_l2(KS, lg + 1, 3, "R7");
    send(KS, lg, 2); send(KS, lg + 1, 3);
    exp_l2(KL, lg, 4, "R7");
    send(KL, lg + 2, 4);
    exp_m++;
    exp_ret(4, "R7");
    rsp(1'b0, lg, 4);
    idle(2);
    counts("R7");

    // R8: queue full, then one replay per cycle with requests stalled
    lh = mk(8, 7, 0);
    exp_l2(KL, lh, 5, "R1");
    send(KL, lh, 5);
    send(KL, lh + 1, 6); send(KL, lh + 2, 7); send(KL, lh + 3, 8); send(KL, lh, 9);
    exp_m++;
    check(req_ready == 1'b0, "R8", "req_ready with full queue", int'(req_ready), 0);
    exp_ret(5, "R8");
    for (int k = 6; k <= 9; k++) exp_hit(k, "R8");
    rsp(1'b0, lh, 5);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(hit_valid == 1'b1, "R8", "replay hit each cycle", int'(hit_valid), 1);
      if (k < 3) check(req_ready == 1'b0, "R8", "req_ready during replay", int'(req_ready), 0);
    end
    check(req_ready == 1'b1, "R8", "req_ready after drain", int'(req_ready), 1);
    exp_h += 4;
    idle(1);
    counts("R8");

    // R9: both counters saturate
    for (int k = 0; k < 7; k++) begin
      exp_hit(k, "R9");
      send(KL, lh + 1, k);
      exp_h++;
    end
    idle(2);
    counts("R9");
    for (int k = 0; k < 8; k++) begin
      exp_l2(KL, mk(20 + k, k, 0), k, "R9");
      send(KL, mk(20 + k, k, 0), k);
      exp_m++;
      exp_ret(k, "R9");
      rsp(1'b0, mk(20 + k, k, 0), k);
    end
    idle(3);
    counts("R9");
    check(int'(miss_count) == 15, "R9", "miss_count held at max", int'(miss_count), 15);

    check(hit_q.size() == 0, "R3", "hits left unseen", hit_q.size(), 0);
    check(ret_q.size() == 0, "R3", "returns left unseen", ret_q.size(), 0);
    check(l2_q.size() == 0, "R1", "L2 requests left unseen", l2_q.size(), 0);
    summary();
    $finish;
  end
endmodule